// File: doc/BRIEF.md
# Shared-Counter Four-Channel PWM Generator

This block drives up to four edge-aligned pulse-width-modulated outputs from a single up-counter. A common prescaler divides the clock into counter ticks. A common reload value sets where the counter wraps. Every channel compares the counter against its own compare value. Each channel has a main output and a complementary output. Each of these has its own enable and its own inversion bit, and one global gate can force every output low at once.

Software sets the block up through a small word-wide register port: a write strobe, an address and write data, with read data returned combinationally. Compare values always pass through a shadow copy. The reload value can either take effect at once or wait in a shadow copy, as a control bit selects. A shadow copy reaches the active copy at an update event: either the counter wrapping or a software-forced update. The instantiated channel count and the presence of complementary outputs are parameters. Enable bits that do not exist read back as zero, so software can discover what was built.

Top module: `quad_pwm_gen`

## Requirements
- R1: All channels share one counter, which advances once every (prescale+1) clocks and wraps to 0 after reaching the reload value, so the PWM period is (reload+1)*(prescale+1) clocks. Register map: 0 control, 1 output config, 2 prescale, 3 reload, 4+n compare of channel n, 8 event.
- R2: A channel's reference is active while the counter is below its active compare value. A compare of 0 gives a constant inactive reference, and a compare above the reload value gives a constant active reference.
- R3: Output config holds one 4-bit group per channel starting at bit 4n: bit 4n main enable, 4n+1 main invert, 4n+2 complementary enable, 4n+3 complementary invert. A set invert bit inverts that output.
- R4: The complementary output is the inverse of the reference, taken before its own invert bit. An output whose enable is 0 drives 0.
- R5: While control bit 2 (output gate) is 0, every main and complementary output is 0.
- R6: The counter and prescaler advance only while control bit 0 (run) is 1. Otherwise the outputs hold their values.
- R7: A written compare value becomes active only at the next update event. Until then the channel keeps its old compare value.
- R8: With control bit 1 (reload preload) set, a written reload value becomes active only at the next update event. With the bit clear, the written value applies at once.
- R9: Writing 1 to bit 0 of the event register makes an immediate update event: the counter and prescaler restart at 0, and the prescale, reload and compare values are copied into their active registers. The event register reads 0.
- R10: All registers reset to 0 and read back what was written. Output-config bits of channels at or above NCH, and complementary bits when HAS_COMP is 0, cannot be set and read 0. Those outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pwm_out | output | 4 | Main outputs, one per channel |
| pwm_out_n | output | 4 | Complementary outputs, one per channel |

## Verification
The bench goes after the compare extremes: 0, reload+1 and above the reload value. A design comparing with less-or-equal, or clipping at the reload value, would give a one-tick sliver or lose the solid-high output. It writes a compare value and a shorter reload value in the middle of a period, with preload on and off. A design without the shadow copies would change the pulse or shorten the period at once, and a design ignoring the preload bit would wait one full period too long. It also reads back every output-config bit of a missing channel, and drives a missing channel's outputs. A design without the mask would read back ones there and toggle that pin. Further checks cover the prescaler, the stopped counter and the output gate, which show up as a wrong high-tick count or outputs that are not 0.

// File: rtl/quad_pwm_gen.sv
module quad_pwm_gen #(
  parameter int NCH      = 3,
  parameter bit HAS_COMP = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [3:0]  pwm_out,
  output logic [3:0]  pwm_out_n
);
  function automatic logic [15:0] impl_mask();
    logic [15:0] m;
    m = '0;
    for (int n = 0; n < 4; n++) begin
      if (n < NCH) begin
        m[4*n]   = 1'b1;
        m[4*n+1] = 1'b1;
        if (HAS_COMP) begin
          m[4*n+2] = 1'b1;
          m[4*n+3] = 1'b1;
        end
      end
    end
    return m;
  endfunction

  localparam logic [15:0] CFG_MASK = impl_mask();

  logic [2:0]        ctrl;
  logic [15:0]       cfg;
  logic [15:0]       psc_sh, psc_act, arr_sh, arr_act, pdiv, cnt;
  logic [3:0][15:0]  cmp_sh, cmp_act;
  logic              ug, tick, wrap, uev;
  logic [15:0]       arr_eff;

  assign ug      = bus_wr && bus_addr == 4'd8 && bus_wdata[0];
  assign tick    = ctrl[0] && pdiv == psc_act;
  assign arr_eff = ctrl[1] ? arr_act : arr_sh;
  assign wrap    = tick && cnt == arr_eff;
  assign uev     = ug || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      cfg     <= '0;
      psc_sh  <= '0;
      arr_sh  <= '0;
      cmp_sh  <= '0;
      psc_act <= '0;
      arr_act <= '0;
      cmp_act <= '0;
      pdiv    <= '0;
      cnt     <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          4'd0: ctrl <= bus_wdata[2:0];
          4'd1: cfg <= bus_wdata & CFG_MASK;
          4'd2: psc_sh <= bus_wdata;
          4'd3: arr_sh <= bus_wdata;
          4'd4, 4'd5, 4'd6, 4'd7: cmp_sh[bus_addr[1:0]] <= bus_wdata;
          default: ;
        endcase
      end
      if (ug) begin
        pdiv <= '0;
        cnt  <= '0;
      end else if (tick) begin
        pdiv <= '0;
        cnt  <= wrap ? 16'd0 : cnt + 16'd1;
      end else if (ctrl[0]) begin
        pdiv <= pdiv + 16'd1;
      end
      if (uev) begin
        psc_act <= psc_sh;
        arr_act <= arr_sh;
        cmp_act <= cmp_sh;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      4'd0: bus_rdata = {13'd0, ctrl};
      4'd1: bus_rdata = cfg;
      4'd2: bus_rdata = psc_sh;
      4'd3: bus_rdata = arr_sh;
      4'd4, 4'd5, 4'd6, 4'd7: bus_rdata = cmp_sh[bus_addr[1:0]];
      default: bus_rdata = '0;
    endcase
  end

  for (genvar n = 0; n < 4; n++) begin : g_ch
    logic refsig;
    assign refsig       = cnt < cmp_act[n];
    assign pwm_out[n]   = ctrl[2] & cfg[4*n]   & (refsig ^ cfg[4*n+1]);
    assign pwm_out_n[n] = ctrl[2] & cfg[4*n+2] & (~refsig ^ cfg[4*n+3]);
  end
endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk #(
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       ctrl,
  input logic [15:0]      cfg,
  input logic [15:0]      cnt,
  input logic [3:0][15:0] cmp_act,
  input logic             uev,
  input logic             ug,
  input logic [3:0]       out,
  input logic [3:0]       outn
);
  logic [3:0] same_pol;
  always_comb
    for (int n = 0; n < 4; n++) same_pol[n] = ~(cfg[4*n+1] ^ cfg[4*n+3]);

  AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] |-> (out == 4'd0 && outn == 4'd0)); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ug) |=> $stable(cnt)); // R6
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !uev |=> $stable(cmp_act)); // R7
  AST_FORCE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> cnt == 16'd0); // R9
  AST_COMP_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out & outn & same_pol) == 4'd0); // R4
  AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((out >> NCH) == 4'd0 && (outn >> NCH) == 4'd0)); // R10
endmodule

bind quad_pwm_gen quad_pwm_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cfg(cfg), .cnt(cnt),
  .cmp_act(cmp_act), .uev(uev), .ug(ug), .out(pwm_out), .outn(pwm_out_n)
);

// File: tb/sim_quad_pwm_gen.sv
module sim_quad_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  pwm_out, pwm_out_n;
  int total = 0, bad = 0;
  bit done = 1'b0;

  quad_pwm_gen u0 (.*);

  always #4 clk = ~clk;

  // cfg, cmp0, cmp1, exp main0, exp comp0, exp main1, exp comp1 (reload 9, prescale 0)
  localparam int unsigned VEC [6][7] = '{
    '{32'h0055,  3,  7,  3, 7,  7, 3},
    '{32'h00FF,  3,  0,  7, 3, 10, 0},
    '{32'h0051, 12, 10, 10, 0, 10, 0},
    '{32'h00AA,  5,  5,  0, 0,  0, 0},
    '{32'h0035,  1,  9,  1, 9,  1, 0},
    '{32'h0011, 10,  9, 10, 0,  9, 0}
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic count_hi(int cycles, int ch, output int m, output int c);
    m = 0; c = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      m += int'(pwm_out[ch]);
      c += int'(pwm_out_n[ch]);
    end
  endtask

  task automatic until_hi(output int k);
    k = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (pwm_out[0] && k == 0) k = i;
      if (k != 0) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int m, c, k;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset values
    rd(4'd0, r); chk("R10 reset ctrl", r, 0);
    rd(4'd1, r); chk("R10 reset cfg", r, 0);
    rd(4'd3, r); chk("R10 reset reload", r, 0);
    chk("R10 reset outputs", {pwm_out, pwm_out_n}, 0);

    wr(4'd2, 16'd0);
    wr(4'd3, 16'd9);
    wr(4'd0, 16'h7);
    rd(4'd3, r); chk("R10 reload readback", r, 9);

    // table: R2 R3 R4
    foreach (VEC[i]) begin
      wr(4'd4, 16'(VEC[i][1]));
      wr(4'd5, 16'(VEC[i][2]));
      wr(4'd1, 16'(VEC[i][0]));
      wr(4'd8, 16'd1);
      fork
        count_hi(10, 0, m, c);
      join
      chk($sformatf("R2/R3 vec%0d main0", i), m, VEC[i][3]);
      chk($sformatf("R4 vec%0d comp0", i), c, VEC[i][4]);
      wr(4'd8, 16'd1);
      count_hi(10, 1, m, c);
      chk($sformatf("R3 vec%0d main1", i), m, VEC[i][5]);
      chk($sformatf("R4 vec%0d comp1", i), c, VEC[i][6]);
    end

    // R3: channel 2 group at bits 8..11
    wr(4'd6, 16'd4);
    wr(4'd1, 16'h0500);
    wr(4'd8, 16'd1);
    count_hi(10, 2, m, c);
    chk("R3 ch2 main", m, 4);
    chk("R4 ch2 comp", c, 6);

    // R10: missing channel 3 bits masked and pin quiet
    wr(4'd7, 16'd5);
    wr(4'd1, 16'hFFFF);
    rd(4'd1, r); chk("R10 cfg mask readback", r, 16'h0FFF);
    wr(4'd8, 16'd1);
    count_hi(10, 3, m, c);
    chk("R10 ch3 main quiet", m, 0);
    chk("R10 ch3 comp quiet", c, 0);
    rd(4'd8, r); chk("R9 event reads 0", r, 0);

    // R5: gate off
    wr(4'd4, 16'd5);
    wr(4'd1, 16'h0055);
    wr(4'd0, 16'h3);
    wr(4'd8, 16'd1);
    count_hi(10, 0, m, c);
    chk("R5 gated main", m, 0);
    chk("R5 gated comp", c, 0);

    // R1: prescale 1 doubles period
    wr(4'd0, 16'h7);
    wr(4'd4, 16'd1);
    wr(4'd1, 16'h0001);
    wr(4'd2, 16'd1);
    wr(4'd8, 16'd1);
    count_hi(20, 0, m, c);
    chk("R1 prescale high ticks", m, 2);
    count_hi(40, 0, m, c);
    chk("R1 prescale two periods", m, 4);
    wr(4'd2, 16'd0);

    // R6: stopped counter holds
    wr(4'd4, 16'd3);
    wr(4'd0, 16'h6);
    wr(4'd8, 16'd1);
    count_hi(15, 0, m, c);
    chk("R6 stopped holds", m, 15);

    // R7: compare preload
    wr(4'd0, 16'h7);
    wr(4'd8, 16'd1);
    wr(4'd4, 16'd8);
    repeat (3) @(negedge clk);
    chk("R7 old compare kept", pwm_out[0], 0);
    repeat (10) @(negedge clk);
    chk("R7 new compare after update", pwm_out[0], 1);

    // R8: reload preload on
    wr(4'd4, 16'd1);
    wr(4'd3, 16'd9);
    wr(4'd8, 16'd1);
    wr(4'd3, 16'd5);
    until_hi(k); chk("R8 preload old period", k, 10);
    until_hi(k); chk("R8 preload new period", k, 6);
    // R8: reload preload off
    wr(4'd3, 16'd9);
    wr(4'd0, 16'h5);
    wr(4'd8, 16'd1);
    wr(4'd3, 16'd5);
    until_hi(k); chk("R8 immediate reload", k, 6);

    // R9: forced update restarts counter
    wr(4'd3, 16'd9);
    wr(4'd0, 16'h7);
    wr(4'd8, 16'd1);
    repeat (4) @(negedge clk);
    wr(4'd8, 16'd1);
    @(negedge clk);
    chk("R9 restart at 0", pwm_out[0], 1);
    until_hi(k); chk("R9 full period after restart", k, 10);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule